// File: doc/BRIEF.md
# Core Permission Delegation Unit

This block holds the identity of one processing core: its own address and its permission mask. A set bit in the mask marks an address bit that is fixed for this core and for every core below it in the launch hierarchy. The unit also holds a second pair, the child pair, which is handed to any child core that this core starts. When a core is started, its own pair is written through a load port, and the child pair takes the same values.

Software narrows the child pair with a set-child command. The stored child mask is the requested mask ORed with the core's own mask, so the child can never hold fewer fixed bits than its parent. The child address keeps the parent's bits wherever the parent's mask is set and takes the requested bits everywhere else. A separate combinational privilege check compares a target core's reported address with this core's address under this core's mask. A control-request path uses that check: every request is acknowledged, but only a request made with privilege produces an effect strobe.

Top module: `cpd_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, the own mask and the child mask read all ones, the own address and the child address read zero, and `ctl_ack_o` and `ctl_fire_o` are 0.
- R2: A load (`load_i` = 1) makes both the own pair and the child pair equal to `load_addr_i` / `load_perm_i` on the cycle after the load edge.
- R3: A set-child command (`set_i` = 1 without load) makes the child mask equal to `set_perm_i` OR the current own mask on the next cycle. The child mask therefore always covers every set bit of the own mask.
- R4: A set-child command makes the child address equal to (own address AND own mask) OR (`set_addr_i` AND NOT own mask) on the next cycle. The child address always matches the own address on the bits set in the own mask.
- R5: Without load or set, the own pair and the child pair keep their values. A set-child command never changes the own pair.
- R6: When load and set are both high in one cycle, the load takes effect and the set is dropped.
- R7: `priv_o` is 1 exactly when (`tgt_addr_i` AND own mask) equals (own address AND own mask). It is combinational and follows `tgt_addr_i` in the same cycle.
- R8: A control request (`ctl_req_i` = 1) is always acknowledged on `ctl_ack_o` one cycle later. `ctl_fire_o` rises in that same cycle only if `priv_o` was 1 when the request was sampled. A request without privilege changes no stored pair.
- R9: The readback words are DATA_W bits wide, with the 32-bit address or mask in bits [31:0] and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Inception load strobe |
| load_addr_i | input | 32 | Own address to load |
| load_perm_i | input | 32 | Own mask to load |
| set_i | input | 1 | Set-child command strobe |
| set_addr_i | input | 32 | Requested child address |
| set_perm_i | input | 32 | Requested child mask |
| tgt_addr_i | input | 32 | Address reported by the target bus |
| ctl_req_i | input | 1 | Control request on the target |
| own_addr_o | output | DATA_W | Own address readback word |
| own_perm_o | output | DATA_W | Own mask readback word |
| child_addr_o | output | DATA_W | Child address word |
| child_perm_o | output | DATA_W | Child mask word |
| priv_o | output | 1 | Privilege over the target |
| ctl_ack_o | output | 1 | Request acknowledged (always) |
| ctl_fire_o | output | 1 | Request takes effect |

## Verification
The privilege flag has no latency. The bench checks it 1 ns after it drives the target address on a falling edge, against a model that still holds the pre-edge pair. Load and set results, and the acknowledge and effect strobes, are due one cycle later. The bench drives each stimulus on a falling edge, updates its model at the next rising edge, and compares at the falling edge after that, which is the first point where the registered outputs are settled. It also holds the strobes low for one more cycle to confirm that the acknowledge lasts only one cycle and that the stored pairs stay as they were.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    parameter int unsigned CPD_ADDR_W = 32;

    typedef logic [CPD_ADDR_W-1:0] cpd_word_t;

    typedef struct packed {
        cpd_word_t addr;
        cpd_word_t perm;
    } cpd_pair_t;

    typedef enum logic [1:0] {
        CHILD_HOLD = 2'd0,
        CHILD_LOAD = 2'd1,
        CHILD_SET  = 2'd2
    } child_cmd_e;

    localparam cpd_pair_t CPD_RESET_PAIR = '{addr: '0, perm: '1};

    function automatic cpd_word_t narrow_mask(input cpd_word_t parent, input cpd_word_t req);
        return parent | req;
    endfunction

    function automatic cpd_word_t merge_addr(input cpd_word_t p_addr, input cpd_word_t p_perm,
                                             input cpd_word_t req);
        return (p_addr & p_perm) | (req & ~p_perm);
    endfunction

    function automatic logic covers(input cpd_word_t own_addr, input cpd_word_t own_perm,
                                    input cpd_word_t tgt);
        return (tgt & own_perm) == (own_addr & own_perm);
    endfunction

endpackage

// File: rtl/cpd_own_reg.sv
module cpd_own_reg
    import cpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  cpd_pair_t load_pair_i,
    output cpd_pair_t own_o
);
    cpd_pair_t own_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= CPD_RESET_PAIR;
        end else if (load_i) begin
            own_q <= load_pair_i;
        end
    end

    assign own_o = own_q;

    AST_OWN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(own_q)); // R5

    AST_OWN_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_i |=> own_q == $past(load_pair_i)); // R2

endmodule

// File: rtl/cpd_child_reg.sv
module cpd_child_reg
    import cpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  cpd_pair_t load_pair_i,
    input  logic      set_i,
    input  cpd_pair_t set_pair_i,
    input  cpd_pair_t own_i,
    output cpd_pair_t child_o
);
    child_cmd_e cmd;
    cpd_pair_t  child_q;
    cpd_pair_t  child_d;

    always_comb begin
        if (load_i)     cmd = CHILD_LOAD;
        else if (set_i) cmd = CHILD_SET;
        else            cmd = CHILD_HOLD;
    end

    always_comb begin
        child_d = child_q;
        unique case (cmd)
            CHILD_LOAD: child_d = load_pair_i;
            CHILD_SET: begin
                child_d.perm = narrow_mask(own_i.perm, set_pair_i.perm);
                child_d.addr = merge_addr(own_i.addr, own_i.perm, set_pair_i.addr);
            end
            default:    child_d = child_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) child_q <= CPD_RESET_PAIR;
        else     child_q <= child_d;
    end

    assign child_o = child_q;

    AST_CHILD_NARROW: assert property (@(posedge clk) disable iff (rst)
        (child_q.perm & own_i.perm) == own_i.perm); // R3

    AST_CHILD_ADDR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (child_q.addr & own_i.perm) == (own_i.addr & own_i.perm)); // R4

    AST_CHILD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !set_i) |=> $stable(child_q)); // R5

    AST_CHILD_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> child_q == $past(load_pair_i)); // R6

endmodule

// File: rtl/cpd_priv_check.sv
module cpd_priv_check
    import cpd_pkg::*;
(
    input  cpd_pair_t own_i,
    input  cpd_word_t tgt_addr_i,
    output logic      priv_o
);
    assign priv_o = covers(own_i.addr, own_i.perm, tgt_addr_i);
endmodule

// File: rtl/cpd_ctl_gate.sv
module cpd_ctl_gate (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic priv_i,
    output logic ack_o,
    output logic fire_o
);
    logic ack_q;
    logic fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            ack_q  <= req_i;
            fire_q <= req_i & priv_i;
        end
    end

    assign ack_o  = ack_q;
    assign fire_o = fire_q;

    AST_CTL_ACK: assert property (@(posedge clk) disable iff (rst)
        req_i |=> ack_o); // R8

    AST_CTL_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        (req_i && !priv_i) |=> !fire_o); // R8

    AST_CTL_FIRE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> ack_o); // R8

endmodule

// File: rtl/cpd_unit.sv
module cpd_unit
    import cpd_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [31:0]       load_addr_i,
    input  logic [31:0]       load_perm_i,
    input  logic              set_i,
    input  logic [31:0]       set_addr_i,
    input  logic [31:0]       set_perm_i,
    input  logic [31:0]       tgt_addr_i,
    input  logic              ctl_req_i,
    output logic [DATA_W-1:0] own_addr_o,
    output logic [DATA_W-1:0] own_perm_o,
    output logic [DATA_W-1:0] child_addr_o,
    output logic [DATA_W-1:0] child_perm_o,
    output logic              priv_o,
    output logic              ctl_ack_o,
    output logic              ctl_fire_o
);
    localparam int unsigned PAD_W = DATA_W - CPD_ADDR_W;

    cpd_pair_t load_pair;
    cpd_pair_t set_pair;
    cpd_pair_t own;
    cpd_pair_t child;
    logic      priv;

    assign load_pair = '{addr: load_addr_i, perm: load_perm_i};
    assign set_pair  = '{addr: set_addr_i,  perm: set_perm_i};

    cpd_own_reg u_own (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .load_pair_i(load_pair),
        .own_o      (own)
    );

    cpd_child_reg u_child (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .load_pair_i(load_pair),
        .set_i      (set_i),
        .set_pair_i (set_pair),
        .own_i      (own),
        .child_o    (child)
    );

    cpd_priv_check u_priv (
        .own_i     (own),
        .tgt_addr_i(tgt_addr_i),
        .priv_o    (priv)
    );

    cpd_ctl_gate u_ctl (
        .clk   (clk),
        .rst   (rst),
        .req_i (ctl_req_i),
        .priv_i(priv),
        .ack_o (ctl_ack_o),
        .fire_o(ctl_fire_o)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign own_addr_o   = {{PAD_W{1'b0}}, own.addr};
            assign own_perm_o   = {{PAD_W{1'b0}}, own.perm};
            assign child_addr_o = {{PAD_W{1'b0}}, child.addr};
            assign child_perm_o = {{PAD_W{1'b0}}, child.perm};
        end else begin : g_nopad
            assign own_addr_o   = own.addr;
            assign own_perm_o   = own.perm;
            assign child_addr_o = child.addr;
            assign child_perm_o = child.perm;
        end
    endgenerate

    assign priv_o = priv;

    AST_SET_KEEPS_OWN: assert property (@(posedge clk) disable iff (rst)
        (set_i && !load_i) |=> $stable(own)); // R5

endmodule

// File: tb/cpd_unit_bench.sv
`timescale 1ns/1ps
module cpd_unit_bench;
    localparam int unsigned DATA_W = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_i = 0, set_i = 0, ctl_req_i = 0;
    logic [31:0] load_addr_i = 0, load_perm_i = 0, set_addr_i = 0, set_perm_i = 0, tgt_addr_i = 0;
    logic [DATA_W-1:0] own_addr_o, own_perm_o, child_addr_o, child_perm_o;
    logic priv_o, ctl_ack_o, ctl_fire_o;

    always #10 clk = ~clk;

    cpd_unit #(.DATA_W(DATA_W)) u_cpd_unit (
        .clk(clk), .rst(rst), .load_i(load_i), .load_addr_i(load_addr_i),
        .load_perm_i(load_perm_i), .set_i(set_i), .set_addr_i(set_addr_i),
        .set_perm_i(set_perm_i), .tgt_addr_i(tgt_addr_i), .ctl_req_i(ctl_req_i),
        .own_addr_o(own_addr_o), .own_perm_o(own_perm_o), .child_addr_o(child_addr_o),
        .child_perm_o(child_perm_o), .priv_o(priv_o), .ctl_ack_o(ctl_ack_o),
        .ctl_fire_o(ctl_fire_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_oa, m_op, m_ca, m_cp;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pairs(input string tag);
        check({tag, " own addr"},   own_addr_o,   {32'h0, m_oa});
        check({tag, " own perm"},   own_perm_o,   {32'h0, m_op});
        check({tag, " child addr"}, child_addr_o, {32'h0, m_ca});
        check({tag, " child perm"}, child_perm_o, {32'h0, m_cp});
    endtask

    function automatic logic exp_priv(input logic [31:0] t);
        return (t & m_op) == (m_oa & m_op);
    endfunction

    typedef struct packed {
        logic        ld;
        logic        st;
        logic [31:0] la;
        logic [31:0] lp;
        logic [31:0] sa;
        logic [31:0] sp;
        logic [31:0] tgt;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 32'h1234_5600, 32'hFFFF_0000, 32'h0, 32'h0, 32'h0000_0000},
        '{1'b0, 1'b1, 32'h0, 32'h0, 32'hABCD_EF77, 32'h0000_FF00, 32'h1234_0000},
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1234_FFFF},
        '{1'b0, 1'b1, 32'h0, 32'h0, 32'h0000_0001, 32'h0F00_00F0, 32'h1235_0000},
        '{1'b1, 1'b1, 32'h8000_0000, 32'hF000_0000, 32'h7777_7777, 32'hFFFF_FFFF, 32'h8FFF_FFFF},
        '{1'b0, 1'b1, 32'h0, 32'h0, 32'h5A5A_5A5A, 32'h0000_0000, 32'h9000_0000},
        '{1'b1, 1'b0, 32'hCAFE_0000, 32'h0000_0000, 32'h0, 32'h0, 32'h1111_2222}
    };

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_oa = 0; m_op = '1; m_ca = 0; m_cp = '1;
        repeat (2) @(negedge clk);
        check_pairs("R1 reset");
        check("R1 ack in reset", {63'h0, ctl_ack_o}, 64'h0);
        check("R1 fire in reset", {63'h0, ctl_fire_o}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check_pairs("R1 after reset");

        // Vector table: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            load_i = VECS[i].ld; set_i = VECS[i].st;
            load_addr_i = VECS[i].la; load_perm_i = VECS[i].lp;
            set_addr_i = VECS[i].sa; set_perm_i = VECS[i].sp;
            tgt_addr_i = VECS[i].tgt;
            #1;
            check($sformatf("R7 priv vec %0d", i), {63'h0, priv_o}, {63'h0, exp_priv(VECS[i].tgt)});
            @(posedge clk);
            if (VECS[i].ld) begin
                m_oa = VECS[i].la; m_op = VECS[i].lp; m_ca = VECS[i].la; m_cp = VECS[i].lp;
            end else if (VECS[i].st) begin
                m_cp = m_op | VECS[i].sp;
                m_ca = (m_oa & m_op) | (VECS[i].sa & ~m_op);
            end
            @(negedge clk);
            load_i = 0; set_i = 0;
            check_pairs($sformatf("R2 R3 R4 R5 R6 R9 vec %0d", i));
        end

        // Directed: narrow own mask for control tests
        load_i = 1; load_addr_i = 32'h00A0_0000; load_perm_i = 32'h00F0_0000;
        @(posedge clk);
        m_oa = 32'h00A0_0000; m_op = 32'h00F0_0000; m_ca = m_oa; m_cp = m_op;
        @(negedge clk); load_i = 0;
        check_pairs("R2 directed load");

        // R7 boundary: differs only in an unmasked bit -> privileged; in a masked bit -> not
        tgt_addr_i = 32'hFFAF_FFFF; #1;
        check("R7 unmasked bits free", {63'h0, priv_o}, 64'h1);
        tgt_addr_i = 32'h00B0_0000; #1;
        check("R7 masked bit differs", {63'h0, priv_o}, 64'h0);

        // R8 privileged request
        tgt_addr_i = 32'h12A3_4567; ctl_req_i = 1;
        @(negedge clk); ctl_req_i = 0;
        check("R8 ack priv", {63'h0, ctl_ack_o}, 64'h1);
        check("R8 fire priv", {63'h0, ctl_fire_o}, 64'h1);
        @(negedge clk);
        check("R8 ack one cycle", {63'h0, ctl_ack_o}, 64'h0);

        // R8 unprivileged request: ack, no fire, no state change
        tgt_addr_i = 32'h0050_0000; ctl_req_i = 1;
        @(negedge clk); ctl_req_i = 0;
        check("R8 ack unpriv", {63'h0, ctl_ack_o}, 64'h1);
        check("R8 no fire unpriv", {63'h0, ctl_fire_o}, 64'h0);
        @(negedge clk);
        check_pairs("R8 R5 no effect");

        // R5: set leaves own pair, R3 requested mask cannot clear parent bits
        set_i = 1; set_perm_i = 32'h0000_0000; set_addr_i = 32'hFFFF_FFFF;
        @(posedge clk);
        m_cp = m_op; m_ca = (m_oa & m_op) | (32'hFFFF_FFFF & ~m_op);
        @(negedge clk); set_i = 0;
        check_pairs("R3 R4 R5 set zero mask");

        // R1 reset again mid-run
        rst = 1;
        @(posedge clk);
        m_oa = 0; m_op = '1; m_ca = 0; m_cp = '1;
        @(negedge clk); rst = 0;
        check_pairs("R1 re-reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule